// File: doc/BRIEF.md
# Serial Status Flag Register

This block is the eight-bit status register of an asynchronous serial transceiver. It collects events from the transmit and receive shift-register logic into sticky flags: transmitter data empty, transmitter end, receiver data full, and three receive error flags (overrun, framing, parity). It also holds the multiprocessor bit of the last accepted frame and a writable multiprocessor bit for the next transmitted frame. The receive parity check is computed inside the block from the received data word, the received parity bit and the selected sense.

Host software clears a sticky flag in two steps. It first reads the register while the flag is 1, and then writes 0 to that bit position. A write of 0 without that prior read does nothing. A DMA-style agent clears the data flags as a side effect of its data-register accesses. Three level interrupt outputs follow the transmit-empty flag, the receive-full flag and the OR of the three error flags.

Top module: `ser_status_reg`

## Requirements
- R1: Field positions in `rd_data` and `wr_data`: bit 7 transmitter data empty (TXE), bit 6 receiver data full (RXF), bit 5 overrun (OVR), bit 4 framing error (FRM), bit 3 parity error (PAR), bit 2 transmitter end (TEND), bit 1 received multiprocessor bit (MPR), bit 0 multiprocessor bit to send (MPT).
- R2: Synchronous reset gives `rd_data` = 8'h84, `irq_txe` = 1, `irq_rx` = 0, `irq_err` = 0 and `mp_tx_bit` = 0.
- R3: For bits 7..3, a write (reg_sel and wr_stb) with a 0 in a bit clears that flag only if an earlier read (reg_sel and rd_stb) saw the flag at 1 and the flag has stayed 1 since. Each write uses up the qualification. Writing 1 to bits 7..3 never changes them.
- R4: TXE is set in every cycle that `tx_en` is 0, and on a `tx_load` pulse.
- R5: A `rx_done` pulse while RXF is 0, with `rx_stop_bit` 1 and no parity error, sets RXF.
- R6: A `rx_done` pulse while RXF is 1 sets OVR and leaves RXF, FRM, PAR and MPR unchanged.
- R7: A `rx_done` pulse while RXF is 0 with `rx_stop_bit` 0 sets FRM and does not set RXF.
- R8: With `par_en` 1, a `rx_done` pulse while RXF is 0 sets PAR (and not RXF) when the XOR of `rx_data` and `rx_par_bit` differs from `par_odd` (0 = even, 1 = odd). With `par_en` 0, PAR is never set.
- R9: TEND is read-only. It is set while `tx_en` is 0, or on `tx_last_bit` when TXE is 1. It is cleared whenever TXE is cleared by software or by DMA.
- R10: MPR is read-only and takes `rx_mp_bit` on each `rx_done` while RXF is 0. MPT is plain read/write and drives `mp_tx_bit`.
- R11: `dma_tdr_wr` clears TXE and TEND, and `dma_rdr_rd` clears RXF.
- R12: When a hardware set and a software or DMA clear of the same flag fall in one cycle, the flag ends up 1.
- R13: `irq_txe` equals TXE, `irq_rx` equals RXF, and `irq_err` is 1 while any of OVR, FRM or PAR is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Host access targets this register |
| rd_stb | input | 1 | Host read strobe |
| wr_stb | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Register contents |
| tx_en | input | 1 | Transmitter enable level |
| tx_load | input | 1 | Transmit data moved into the shift register |
| tx_last_bit | input | 1 | Last bit of a character is being sent |
| dma_tdr_wr | input | 1 | DMA wrote the transmit data register |
| rx_done | input | 1 | A reception has completed |
| rx_stop_bit | input | 1 | Sampled stop bit of that reception |
| rx_data | input | DATA_W | Received data word |
| rx_par_bit | input | 1 | Received parity bit |
| par_en | input | 1 | Parity checking enabled |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_mp_bit | input | 1 | Received multiprocessor bit |
| dma_rdr_rd | input | 1 | DMA read the receive data register |
| mp_tx_bit | output | 1 | Multiprocessor bit for the next transmit |
| irq_txe | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive-full interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
A software clear and a hardware set of the same flag can land on one edge. The bench provokes this in two ways. It sends a qualified write of 0 to TXE in the same cycle as a `tx_load` pulse, and it pulses `dma_tdr_wr` while `tx_en` is low. It then expects TXE (and TEND, in the second case) to read 1. The parity logic is swept over every data word, both parity-bit values and both parity senses, and each frame's flag pattern is compared with the parity worked out in the bench.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  // Bit positions inside the status word
  localparam int unsigned B_TXE  = 7;
  localparam int unsigned B_RXF  = 6;
  localparam int unsigned B_OVR  = 5;
  localparam int unsigned B_FRM  = 4;
  localparam int unsigned B_PAR  = 3;
  localparam int unsigned B_TEND = 2;
  localparam int unsigned B_MPR  = 1;
  localparam int unsigned B_MPT  = 0;

  localparam int unsigned WORD_W = 8;
  // Number of sticky, software-clearable flags (bits 7..3)
  localparam int unsigned N_STICKY = 5;

  typedef logic [WORD_W-1:0] ssr_word_t;

  // Index of each sticky flag inside the sticky vector (bit 4 = TXE ... bit 0 = PAR)
  localparam int unsigned S_TXE = 4;
  localparam int unsigned S_RXF = 3;
  localparam int unsigned S_OVR = 2;
  localparam int unsigned S_FRM = 1;
  localparam int unsigned S_PAR = 0;

  localparam ssr_word_t RESET_WORD = ssr_word_t'((1 << B_TXE) | (1 << B_TEND));
endpackage

// File: rtl/ssr_clear_qual.sv
module ssr_clear_qual #(
  parameter int unsigned NBITS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_hit,
  input  logic             wr_hit,
  input  logic [NBITS-1:0] flags,
  input  logic [NBITS-1:0] wr_bits,
  output logic [NBITS-1:0] clr_req
);
  // One arm flop per flag. A read seeing the flag at 1 arms it,
  // any write consumes it, and a flag dropping to 0 disarms it.
  for (genvar i = 0; i < NBITS; i++) begin : g_arm
    logic armed;
    always_ff @(posedge clk) begin
      if (rst) begin
        armed <= 1'b0;
      end else if (rd_hit) begin
        armed <= flags[i];
      end else if (wr_hit) begin
        armed <= 1'b0;
      end else begin
        armed <= armed & flags[i];
      end
    end
    assign clr_req[i] = wr_hit & armed & ~wr_bits[i];
  end
endmodule

// File: rtl/ssr_tx_flags.sv
module ssr_tx_flags (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic tx_load,
  input  logic tx_last_bit,
  input  logic dma_tdr_wr,
  input  logic sw_clr_txe,
  output logic txe,
  output logic tend
);
  logic txe_set, txe_clr, tend_set;

  assign txe_set  = ~tx_en | tx_load;
  assign txe_clr  = sw_clr_txe | dma_tdr_wr;
  // End-of-character marker uses the empty flag as it stands before this edge
  assign tend_set = ~tx_en | (tx_last_bit & txe);

  always_ff @(posedge clk) begin
    if (rst) begin
      txe  <= 1'b1;
      tend <= 1'b1;
    end else begin
      if (txe_set)      txe <= 1'b1;
      else if (txe_clr) txe <= 1'b0;

      if (tend_set)     tend <= 1'b1;
      else if (txe_clr) tend <= 1'b0;
    end
  end
endmodule

// File: rtl/ssr_rx_flags.sv
module ssr_rx_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_done,
  input  logic              rx_stop_bit,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par_bit,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rx_mp_bit,
  input  logic              dma_rdr_rd,
  input  logic              sw_clr_rxf,
  input  logic              sw_clr_ovr,
  input  logic              sw_clr_frm,
  input  logic              sw_clr_par,
  output logic              rxf,
  output logic              ovr,
  output logic              frm,
  output logic              par,
  output logic              mpr
);
  logic ones_odd, par_bad, accept, overrun;
  logic rxf_set, frm_set, par_set;

  // Count of ones in data plus parity bit, folded to one bit
  assign ones_odd = (^rx_data) ^ rx_par_bit;
  assign par_bad  = par_en & (ones_odd != par_odd);

  assign overrun = rx_done & rxf;
  assign accept  = rx_done & ~rxf;
  assign frm_set = accept & ~rx_stop_bit;
  assign par_set = accept & par_bad;
  assign rxf_set = accept & rx_stop_bit & ~par_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxf <= 1'b0;
      ovr <= 1'b0;
      frm <= 1'b0;
      par <= 1'b0;
      mpr <= 1'b0;
    end else begin
      if (rxf_set)                       rxf <= 1'b1;
      else if (sw_clr_rxf || dma_rdr_rd) rxf <= 1'b0;

      if (overrun)         ovr <= 1'b1;
      else if (sw_clr_ovr) ovr <= 1'b0;

      if (frm_set)         frm <= 1'b1;
      else if (sw_clr_frm) frm <= 1'b0;

      if (par_set)         par <= 1'b1;
      else if (sw_clr_par) par <= 1'b0;

      if (accept)          mpr <= rx_mp_bit;
    end
  end
endmodule

// File: rtl/ser_status_reg.sv
module ser_status_reg
  import ssr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  input  logic              tx_en,
  input  logic              tx_load,
  input  logic              tx_last_bit,
  input  logic              dma_tdr_wr,
  input  logic              rx_done,
  input  logic              rx_stop_bit,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par_bit,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              rx_mp_bit,
  input  logic              dma_rdr_rd,
  output logic              mp_tx_bit,
  output logic              irq_txe,
  output logic              irq_rx,
  output logic              irq_err
);
  logic rd_hit, wr_hit;
  logic txe, tend, rxf, ovr, frm, par, mpr, mpt;
  logic [N_STICKY-1:0] sticky, clr_req;
  ssr_word_t word;

  assign rd_hit = reg_sel & rd_stb;
  assign wr_hit = reg_sel & wr_stb;

  assign sticky[S_TXE] = txe;
  assign sticky[S_RXF] = rxf;
  assign sticky[S_OVR] = ovr;
  assign sticky[S_FRM] = frm;
  assign sticky[S_PAR] = par;

  ssr_clear_qual #(.NBITS(N_STICKY)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .rd_hit  (rd_hit),
    .wr_hit  (wr_hit),
    .flags   (sticky),
    .wr_bits (wr_data[B_TXE:B_PAR]),
    .clr_req (clr_req)
  );

  ssr_tx_flags u_tx (
    .clk         (clk),
    .rst         (rst),
    .tx_en       (tx_en),
    .tx_load     (tx_load),
    .tx_last_bit (tx_last_bit),
    .dma_tdr_wr  (dma_tdr_wr),
    .sw_clr_txe  (clr_req[S_TXE]),
    .txe         (txe),
    .tend        (tend)
  );

  ssr_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst         (rst),
    .rx_done     (rx_done),
    .rx_stop_bit (rx_stop_bit),
    .rx_data     (rx_data),
    .rx_par_bit  (rx_par_bit),
    .par_en      (par_en),
    .par_odd     (par_odd),
    .rx_mp_bit   (rx_mp_bit),
    .dma_rdr_rd  (dma_rdr_rd),
    .sw_clr_rxf  (clr_req[S_RXF]),
    .sw_clr_ovr  (clr_req[S_OVR]),
    .sw_clr_frm  (clr_req[S_FRM]),
    .sw_clr_par  (clr_req[S_PAR]),
    .rxf         (rxf),
    .ovr         (ovr),
    .frm         (frm),
    .par         (par),
    .mpr         (mpr)
  );

  // Plain read/write bit for the transmitter's multiprocessor bit
  always_ff @(posedge clk) begin
    if (rst)         mpt <= 1'b0;
    else if (wr_hit) mpt <= wr_data[B_MPT];
  end

  always_comb begin
    word         = '0;
    word[B_TXE]  = txe;
    word[B_RXF]  = rxf;
    word[B_OVR]  = ovr;
    word[B_FRM]  = frm;
    word[B_PAR]  = par;
    word[B_TEND] = tend;
    word[B_MPR]  = mpr;
    word[B_MPT]  = mpt;
  end

  assign rd_data   = word;
  assign mp_tx_bit = mpt;
  assign irq_txe   = txe;
  assign irq_rx    = rxf;
  assign irq_err   = ovr | frm | par;
endmodule

// File: rtl/ssr_chk.sv
module ssr_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       reg_sel,
  input logic       wr_stb,
  input logic [7:0] rd_data,
  input logic       tx_en,
  input logic       tx_last_bit,
  input logic       rx_done,
  input logic       rx_stop_bit,
  input logic       par_en,
  input logic       rx_mp_bit,
  input logic       dma_rdr_rd,
  input logic       irq_txe
);
  p_reset_value_r2: assert property (@(posedge clk)
    rst |=> (rd_data == 8'h84) && irq_txe);

  p_txe_when_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> rd_data[7] && rd_data[2]);

  p_rxf_on_good_frame_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rd_data[6] && rx_stop_bit && !par_en) |=> rd_data[6]);

  p_overrun_keeps_data_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rd_data[6] && !dma_rdr_rd && !(reg_sel && wr_stb))
      |=> rd_data[5] && rd_data[6] && $stable(rd_data[1]));

  p_framing_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rd_data[6] && !rx_stop_bit) |=> rd_data[4] && !rd_data[6]);

  p_tend_follows_clear_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_data[7]) && !$past(tx_last_bit)) |-> !rd_data[2]);

  p_mpr_capture_r10: assert property (@(posedge clk) disable iff (rst)
    (rx_done && !rd_data[6]) |=> rd_data[1] == $past(rx_mp_bit));
endmodule

bind ser_status_reg ssr_chk #(.DATA_W(DATA_W)) u_ssr_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_sel     (reg_sel),
  .wr_stb      (wr_stb),
  .rd_data     (rd_data),
  .tx_en       (tx_en),
  .tx_last_bit (tx_last_bit),
  .rx_done     (rx_done),
  .rx_stop_bit (rx_stop_bit),
  .par_en      (par_en),
  .rx_mp_bit   (rx_mp_bit),
  .dma_rdr_rd  (dma_rdr_rd),
  .irq_txe     (irq_txe)
);

// File: tb/test_ser_status_reg.sv
`timescale 1ns/1ps
module test_ser_status_reg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NWORDS = 1 << DATA_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_sel = 0, rd_stb = 0, wr_stb = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic tx_en = 0, tx_load = 0, tx_last_bit = 0, dma_tdr_wr = 0;
  logic rx_done = 0, rx_stop_bit = 1, rx_par_bit = 0, par_en = 0, par_odd = 0;
  logic rx_mp_bit = 0, dma_rdr_rd = 0;
  logic [DATA_W-1:0] rx_data = '0;
  logic mp_tx_bit, irq_txe, irq_rx, irq_err;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ser_status_reg #(.DATA_W(DATA_W)) i_ser_status_reg (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_read(output logic [7:0] v);
    reg_sel = 1; rd_stb = 1;
    v = rd_data;
    tick();
    reg_sel = 0; rd_stb = 0;
  endtask

  task automatic host_write(input logic [7:0] v);
    reg_sel = 1; wr_stb = 1; wr_data = v;
    tick();
    reg_sel = 0; wr_stb = 0;
  endtask

  task automatic frame(input logic stop, input logic mp);
    rx_stop_bit = stop; rx_mp_bit = mp; rx_done = 1;
    tick();
    rx_done = 0; rx_stop_bit = 1;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    tick(); tick();
    rst = 0; tx_en = 1;
    tick();
    // R2 / R1 / R13: reset state
    check("R2", rd_data, 8'h84);
    check("R2", {irq_txe, irq_rx, irq_err, mp_tx_bit}, 8'h08);

    // R3: write 0 without a prior read leaves flags
    host_write(8'h00);
    check("R3", rd_data, 8'h84);
    // R10: MPT read/write
    host_write(8'h01);
    check("R10", rd_data, 8'h85);
    check("R10", {7'd0, mp_tx_bit}, 8'h01);
    // R9 / R10: bits 2 and 1 are read-only
    host_write(8'h06);
    check("R9", rd_data, 8'h84);

    // R3 / R9: qualified clear of TXE also drops TEND
    host_read(rv);
    check("R1", rv, 8'h84);
    host_write(8'h7F);
    check("R3", rd_data, 8'h01);
    check("R13", {7'd0, irq_txe}, 8'h00);

    // R4: tx_load sets TXE, TEND stays
    tx_load = 1; tick(); tx_load = 0;
    check("R4", rd_data, 8'h81);
    // R9: last bit with TXE set raises TEND
    tx_last_bit = 1; tick(); tx_last_bit = 0;
    check("R9", rd_data, 8'h85);
    host_read(rv);
    host_write(8'h7E);
    check("R3", rd_data, 8'h00);
    tx_last_bit = 1; tick(); tx_last_bit = 0;
    check("R9", rd_data, 8'h00);

    // R11: DMA write clears TXE and TEND
    tx_load = 1; tick(); tx_load = 0;
    tx_last_bit = 1; tick(); tx_last_bit = 0;
    check("R9", rd_data, 8'h84);
    dma_tdr_wr = 1; tick(); dma_tdr_wr = 0;
    check("R11", rd_data, 8'h00);

    // R4 / R9: transmitter disabled sets both
    tx_en = 0; tick(); tx_en = 1;
    check("R4", rd_data, 8'h84);

    // R3: qualification lost when the flag drops after the read
    host_read(rv);
    dma_tdr_wr = 1; tick(); dma_tdr_wr = 0;
    tx_load = 1; tick(); tx_load = 0;
    host_write(8'h7F);
    check("R3", rd_data, 8'h81);
    // R3: each write consumes the qualification
    host_read(rv);
    host_write(8'h7E);
    check("R3", rd_data, 8'h00);
    tx_load = 1; tick(); tx_load = 0;
    host_write(8'h7E);
    check("R3", rd_data, 8'h80);

    // R12: hardware set beats same-cycle clear
    host_read(rv);
    tx_load = 1; reg_sel = 1; wr_stb = 1; wr_data = 8'h7E;
    tick();
    tx_load = 0; reg_sel = 0; wr_stb = 0;
    check("R12", rd_data, 8'h80);
    tx_en = 0; dma_tdr_wr = 1; tick(); tx_en = 1; dma_tdr_wr = 0;
    check("R12", rd_data, 8'h84);

    // R5 / R10 / R13: good frame
    frame(1'b1, 1'b1);
    check("R5", rd_data, 8'hC6);
    check("R13", {6'd0, irq_rx, irq_err}, 8'h02);
    // R6: overrun keeps RXF and MPR
    frame(1'b1, 1'b0);
    check("R6", rd_data, 8'hE6);
    check("R13", {7'd0, irq_err}, 8'h01);
    // R11: DMA read clears RXF
    dma_rdr_rd = 1; tick(); dma_rdr_rd = 0;
    check("R11", rd_data, 8'hA6);
    host_read(rv);
    host_write(8'hDE);
    check("R3", rd_data, 8'h86);

    // R7: framing error
    frame(1'b0, 1'b0);
    check("R7", rd_data, 8'h94);
    host_read(rv);
    host_write(8'hEE);
    check("R7", rd_data, 8'h84);

    // R8: parity disabled never flags
    par_en = 0; rx_data = 8'h01; rx_par_bit = 0; par_odd = 1;
    frame(1'b1, 1'b0);
    check("R8", rd_data, 8'hC4);
    dma_rdr_rd = 1; tick(); dma_rdr_rd = 0;

    // R8: sweep of every data word, parity bit and sense
    par_en = 1;
    for (int d = 0; d < NWORDS; d++) begin
      for (int pb = 0; pb < 2; pb++) begin
        for (int od = 0; od < 2; od++) begin
          logic bad;
          rx_data = DATA_W'(d); rx_par_bit = pb[0]; par_odd = od[0];
          bad = ((^DATA_W'(d)) ^ pb[0]) != od[0];
          frame(1'b1, 1'b0);
          check("R8", rd_data, bad ? 8'h8C : 8'hC4);
          if (bad) begin
            host_read(rv);
            host_write(8'hF0);
          end else begin
            dma_rdr_rd = 1; tick(); dma_rdr_rd = 0;
          end
          check("R8", rd_data, 8'h84);
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule